// File: doc/BRIEF.md
# Range-ANS Byte Encoder with Packed Probability Tables

This block turns a stream of symbols into a compressed byte stream using range asymmetric numeral systems. Each input names a symbol and the distribution it is coded under. The block looks up the symbol's cumulative start and frequency in a packed table of quantized cumulative values. It shifts low bytes out of a 32-bit coding state until the state is small enough for that frequency. It then updates the state with an exact quotient and remainder. The quotient comes from a stored reciprocal, a multiply and a one-step correction instead of a divider.

Each distribution occupies only its own valid entries in one shared table, located by a base offset and a symbol count. The last coded index of a distribution is an escape. A symbol at or beyond it is coded as the escape index, followed by its excess over that index split into fixed-width raw chunks at uniform frequency. Emitted bytes enter an output FIFO. A flush command writes out the whole state and restarts coding from the lower bound.

Top module: `rans_encoder`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and the coding state equals the lower bound 2^23, so an immediate flush emits bytes 0x00, 0x00, 0x80, 0x00.
- R2: For distribution d with base offset B and count n, a symbol s < n-1 is coded with start C[B+s] and frequency C[B+s+1]-C[B+s], where C is the packed table of 17-bit cumulative values scaled to a total of 65536.
- R3: Distributions are located only by their written offset and count, so tables of different lengths packed back to back without gaps code correctly.
- R4: Before each coding step, while the state x satisfies x >= f * 2^15, the block emits x[7:0] and shifts x right by 8.
- R5: The coding step sets x to (floor(x/f) << 16) + (x mod f) + start exactly, for every f from 1 to 65535, given the table reciprocal floor(2^32/f).
- R6: A symbol s >= n-1 is coded as index n-1, then v = s-(n-1) follows as two 4-bit chunks, low chunk first, each coded with frequency 4096 and start chunk*4096.
- R7: A flush (in_flush set with in_valid) emits the four state bytes, least significant first, and then resets the state to 2^23.
- R8: Bytes leave through out_data in the order they were produced; out_valid stays high and out_data stays unchanged while out_ready is low.
- R9: When the output FIFO is full, in_ready is low and byte production waits; no byte is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Write enable for the cumulative table |
| tbl_addr | input | 6 | Cumulative table entry address |
| tbl_cdf | input | 17 | Quantized cumulative value for the entry |
| tbl_rcp | input | 33 | floor(2^32 / frequency of the symbol starting at this entry) |
| dsc_we | input | 1 | Write enable for a distribution descriptor |
| dsc_idx | input | 2 | Distribution number to describe |
| dsc_off | input | 6 | Base offset of the distribution in the table |
| dsc_len | input | 6 | Number of coded indices, escape included |
| in_valid | input | 1 | Input command present |
| in_ready | output | 1 | Encoder accepts a command this cycle |
| in_flush | input | 1 | Command is a flush; symbol fields ignored |
| in_dist | input | 2 | Distribution of the symbol |
| in_sym | input | 8 | Symbol value |
| out_valid | output | 1 | FIFO holds a byte |
| out_ready | input | 1 | Consumer takes the byte this cycle |
| out_data | output | 8 | Oldest produced byte |

## Verification
A command is accepted at the rising edge where in_valid and in_ready are both high. in_ready falls one cycle later and returns one cycle after the last coding step. A renormalization byte is written at the edge that ends its cycle, and it shows on out_data one cycle later. The bench therefore never ties a result to a fixed cycle count. It drives at the falling edge, records every byte handed over at a falling edge while out_valid and out_ready are high, and compares the whole recorded sequence against a software coder once the block is idle and drained. The backpressure state is sampled hundreds of cycles into a stall, when the FIFO has had ample time to fill.

// File: rtl/rans_enc_pkg.sv
// Shared constants and state type for the range-ANS encoder.
// Assumes a 32-bit state, 16-bit probability precision and byte output.
package rans_enc_pkg;
    localparam int PREC    = 16;
    localparam int STATE_W = 32;
    localparam int L_LOG   = 23;
    localparam int BYTE_W  = 8;
    // renormalization threshold shift: x >= f << RN_SH forces a byte out
    localparam int RN_SH   = L_LOG - PREC + BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RENORM,
        ST_UPDATE,
        ST_FLUSH
    } enc_st_t;
endpackage

// File: rtl/rans_cdf_store.sv
// Packed cumulative table plus per-distribution offset/count descriptors.
// Looks up start, frequency and reciprocal for a symbol, substituting the
// escape index when the symbol is past the coded range.
// Assumes DEPTH is a power of two and every count written is at least 2.
module rans_cdf_store
    import rans_enc_pkg::*;
#(
    parameter int SYM_W  = 8,
    parameter int DEPTH  = 64,
    parameter int N_DIST = 4,
    parameter int CDF_W  = PREC + 1,
    parameter int RCP_W  = STATE_W + 1
) (
    input  logic                      clk,
    input  logic                      tbl_we,
    input  logic [$clog2(DEPTH)-1:0]  tbl_addr,
    input  logic [CDF_W-1:0]          tbl_cdf,
    input  logic [RCP_W-1:0]          tbl_rcp,
    input  logic                      dsc_we,
    input  logic [$clog2(N_DIST)-1:0] dsc_idx,
    input  logic [$clog2(DEPTH)-1:0]  dsc_off,
    input  logic [$clog2(DEPTH)-1:0]  dsc_len,
    input  logic [$clog2(N_DIST)-1:0] q_dist,
    input  logic [SYM_W-1:0]          q_sym,
    output logic [PREC-1:0]           q_start,
    output logic [PREC-1:0]           q_freq,
    output logic [RCP_W-1:0]          q_rcp,
    output logic                      q_esc,
    output logic [SYM_W-1:0]          q_ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int DW = $clog2(N_DIST);
    localparam int CW = (SYM_W > AW) ? SYM_W : AW;

    logic [CDF_W-1:0] cdf_mem [DEPTH];
    logic [RCP_W-1:0] rcp_mem [DEPTH];
    logic [AW-1:0]    off_mem [N_DIST];
    logic [AW-1:0]    cnt_mem [N_DIST];

    logic [AW-1:0] last_idx, idx, a0, a1;
    logic [CW-1:0] sym_x, lim_x;
    logic [CDF_W-1:0] lo, hi;

    // table entry writes
    always_ff @(posedge clk) begin
        if (tbl_we) begin
            cdf_mem[tbl_addr] <= tbl_cdf;
            rcp_mem[tbl_addr] <= tbl_rcp;
        end
    end

    // descriptor writes
    always_ff @(posedge clk) begin
        if (dsc_we) begin
            off_mem[dsc_idx] <= dsc_off;
            cnt_mem[dsc_idx] <= dsc_len;
        end
    end

    // escape decision and flattened address arithmetic
    always_comb begin
        last_idx = cnt_mem[q_dist] - AW'(1);
        sym_x    = CW'(q_sym);
        lim_x    = CW'(last_idx);
        q_esc    = (sym_x >= lim_x);
        idx      = q_esc ? last_idx : AW'(q_sym);
        a0       = off_mem[q_dist] + idx;
        a1       = a0 + AW'(1);
        lo       = cdf_mem[a0];
        hi       = cdf_mem[a1];
        q_start  = PREC'(lo);
        q_freq   = PREC'(hi - lo);
        q_rcp    = rcp_mem[a0];
        q_ovf    = q_esc ? SYM_W'(sym_x - lim_x) : '0;
    end

    logic [DW-1:0] unused_dw;
    assign unused_dw = dsc_idx;
endmodule

// File: rtl/rans_divfree.sv
// Division-free state update: quotient estimated with a stored reciprocal
// floor(2^32/f), then corrected once by comparing the remainder with f.
// Assumes rcp matches f and that x < f << 15 (renormalized), so the
// result fits in STATE_W bits.
module rans_divfree
    import rans_enc_pkg::*;
#(
    parameter int RCP_W = STATE_W + 1
) (
    input  logic [STATE_W-1:0] x,
    input  logic [PREC-1:0]    freq,
    input  logic [PREC-1:0]    start,
    input  logic [RCP_W-1:0]   rcp,
    output logic [STATE_W-1:0] x_nxt,
    output logic [PREC-1:0]    rem
);
    localparam int PW = STATE_W + RCP_W;

    logic [RCP_W-1:0]   q_est;
    logic [STATE_W-1:0] r0, q, r;
    logic               bump;

    // estimate, back-multiply, one-step calibration, recombine
    always_comb begin
        q_est = RCP_W'((PW'(x) * PW'(rcp)) >> STATE_W);
        r0    = x - (STATE_W'(q_est) * STATE_W'(freq));
        bump  = (r0 >= STATE_W'(freq));
        q     = STATE_W'(q_est) + STATE_W'(bump);
        r     = bump ? (r0 - STATE_W'(freq)) : r0;
        rem   = PREC'(r);
        x_nxt = (q << PREC) + STATE_W'(rem) + STATE_W'(start);
    end
endmodule

// File: rtl/rans_byte_fifo.sv
// Byte FIFO between the renormalization loop and the consumer.
// Assumes DEPTH is a power of two; the writer never pushes when full.
module rans_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          pop;

    assign pop       = out_valid && out_ready;
    assign out_valid = (cnt != '0);
    assign full      = (cnt == CW'(DEPTH));
    assign out_data  = mem[rptr];

    // storage write
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    // pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) wptr <= wptr + AW'(1);
            if (pop)  rptr <= rptr + AW'(1);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
endmodule

// File: rtl/rans_encoder.sv
// Single-channel range-ANS encoder top. Accepts symbol or flush commands,
// renormalizes the state a byte per cycle into the FIFO, applies the
// division-free update, and codes escape excess as uniform raw chunks.
// Assumes tables and descriptors are written before symbols are sent.
module rans_encoder
    import rans_enc_pkg::*;
#(
    parameter int SYM_W      = 8,
    parameter int BYP_W      = 4,
    parameter int CDF_DEPTH  = 64,
    parameter int N_DIST     = 4,
    parameter int FIFO_DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tbl_we,
    input  logic [$clog2(CDF_DEPTH)-1:0]  tbl_addr,
    input  logic [PREC:0]                 tbl_cdf,
    input  logic [STATE_W:0]              tbl_rcp,
    input  logic                          dsc_we,
    input  logic [$clog2(N_DIST)-1:0]     dsc_idx,
    input  logic [$clog2(CDF_DEPTH)-1:0]  dsc_off,
    input  logic [$clog2(CDF_DEPTH)-1:0]  dsc_len,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic                          in_flush,
    input  logic [$clog2(N_DIST)-1:0]     in_dist,
    input  logic [SYM_W-1:0]              in_sym,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [BYTE_W-1:0]             out_data
);
    localparam int RCP_W    = STATE_W + 1;
    localparam int N_CHUNK  = (SYM_W + BYP_W - 1) / BYP_W;
    localparam int KW       = $clog2(N_CHUNK + 1);
    localparam logic [PREC-1:0]    BYP_FREQ = PREC'(1) << (PREC - BYP_W);
    localparam logic [RCP_W-1:0]   BYP_RCP  = RCP_W'(1) << (STATE_W - PREC + BYP_W);
    localparam logic [STATE_W-1:0] L_VAL    = STATE_W'(1) << L_LOG;

    enc_st_t            st;
    logic [STATE_W-1:0] x_r, x_nxt;
    logic [PREC-1:0]    start_r, freq_r, upd_rem;
    logic [RCP_W-1:0]   rcp_r;
    logic [SYM_W-1:0]   ovf_r;
    logic [KW-1:0]      chk_r;
    logic [1:0]         fl_cnt;

    logic [PREC-1:0]    lk_start, lk_freq;
    logic [RCP_W-1:0]   lk_rcp;
    logic               lk_esc;
    logic [SYM_W-1:0]   lk_ovf;
    logic [STATE_W:0]   thr;
    logic               need_rn, full, push;

    rans_cdf_store #(.SYM_W(SYM_W), .DEPTH(CDF_DEPTH), .N_DIST(N_DIST),
                     .CDF_W(PREC + 1), .RCP_W(RCP_W)) u_store (
        .clk(clk), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_cdf(tbl_cdf),
        .tbl_rcp(tbl_rcp), .dsc_we(dsc_we), .dsc_idx(dsc_idx),
        .dsc_off(dsc_off), .dsc_len(dsc_len), .q_dist(in_dist), .q_sym(in_sym),
        .q_start(lk_start), .q_freq(lk_freq), .q_rcp(lk_rcp),
        .q_esc(lk_esc), .q_ovf(lk_ovf)
    );

    rans_divfree #(.RCP_W(RCP_W)) u_upd (
        .x(x_r), .freq(freq_r), .start(start_r), .rcp(rcp_r),
        .x_nxt(x_nxt), .rem(upd_rem)
    );

    rans_byte_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(x_r[BYTE_W-1:0]),
        .full(full), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    // renormalization test and byte push request
    always_comb begin
        thr      = (STATE_W + 1)'(freq_r) << RN_SH;
        need_rn  = ({1'b0, x_r} >= thr);
        push     = !full && (((st == ST_RENORM) && need_rn) || (st == ST_FLUSH));
        in_ready = (st == ST_IDLE) && !full;
    end

    // command acceptance, renormalization, update and flush sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            x_r     <= L_VAL;
            start_r <= '0;
            freq_r  <= '0;
            rcp_r   <= '0;
            ovf_r   <= '0;
            chk_r   <= '0;
            fl_cnt  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (in_valid && in_ready) begin
                    if (in_flush) begin
                        st     <= ST_FLUSH;
                        fl_cnt <= '0;
                    end else begin
                        start_r <= lk_start;
                        freq_r  <= lk_freq;
                        rcp_r   <= lk_rcp;
                        ovf_r   <= lk_ovf;
                        chk_r   <= lk_esc ? KW'(N_CHUNK) : '0;
                        st      <= ST_RENORM;
                    end
                end
                ST_RENORM: begin
                    if (!need_rn)  st  <= ST_UPDATE;
                    else if (!full) x_r <= x_r >> BYTE_W;
                end
                ST_UPDATE: begin
                    x_r <= x_nxt;
                    if (chk_r != '0) begin
                        start_r <= PREC'(ovf_r[BYP_W-1:0]) << (PREC - BYP_W);
                        freq_r  <= BYP_FREQ;
                        rcp_r   <= BYP_RCP;
                        ovf_r   <= ovf_r >> BYP_W;
                        chk_r   <= chk_r - KW'(1);
                        st      <= ST_RENORM;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                ST_FLUSH: if (!full) begin
                    fl_cnt <= fl_cnt + 2'd1;
                    if (fl_cnt == 2'd3) begin
                        x_r <= L_VAL;
                        st  <= ST_IDLE;
                    end else begin
                        x_r <= x_r >> BYTE_W;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R4
    renorm_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_UPDATE) |-> ({1'b0, x_r} < thr));
    // R5
    rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_UPDATE) |-> (upd_rem < freq_r));
    // R5
    state_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (x_r >= L_VAL));
    // R6
    bypass_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_UPDATE && chk_r != '0) |=> (freq_r == BYP_FREQ && st == ST_RENORM));
    // R7
    flush_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FLUSH && fl_cnt == 2'd3 && !full) |=> (st == ST_IDLE && x_r == L_VAL));
endmodule

// File: tb/rans_encoder_test.sv
`timescale 1ns/1ps
module rans_encoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [5:0]  tbl_addr = '0;
    logic [16:0] tbl_cdf = '0;
    logic [32:0] tbl_rcp = '0;
    logic        dsc_we = 1'b0;
    logic [1:0]  dsc_idx = '0;
    logic [5:0]  dsc_off = '0;
    logic [5:0]  dsc_len = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_flush = 1'b0;
    logic [1:0]  in_dist = '0;
    logic [7:0]  in_sym = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;

    int nchk = 0;
    int nerr = 0;
    int cdf_m [64];
    int off_m [4];
    int len_m [4];
    logic [63:0] mx = 64'd1 << 23;
    logic [7:0] exp_q [$];
    logic [7:0] got_q [$];
    bit sender_done;

    rans_encoder uut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_cdf(tbl_cdf), .tbl_rcp(tbl_rcp), .dsc_we(dsc_we), .dsc_idx(dsc_idx),
        .dsc_off(dsc_off), .dsc_len(dsc_len), .in_valid(in_valid),
        .in_ready(in_ready), .in_flush(in_flush), .in_dist(in_dist),
        .in_sym(in_sym), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    always #2 clk = ~clk;

    // record each byte handed over at the coming edge
    always @(negedge clk) if (out_valid && out_ready) got_q.push_back(out_data);

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // software coder step
    task automatic m_code(input logic [63:0] st, input logic [63:0] fr);
        while (mx >= (fr << 15)) begin
            exp_q.push_back(mx[7:0]);
            mx = mx >> 8;
        end
        mx = ((mx / fr) << 16) + (mx % fr) + st;
    endtask

    task automatic m_sym(input int d, input int s);
        int n = len_m[d];
        int a;
        int v;
        if (s < n - 1) begin
            a = off_m[d] + s;
            m_code(cdf_m[a], cdf_m[a+1] - cdf_m[a]);
        end else begin
            a = off_m[d] + n - 1;
            m_code(cdf_m[a], cdf_m[a+1] - cdf_m[a]);
            v = s - (n - 1);
            for (int k = 0; k < 2; k++) begin
                m_code((v & 15) << 12, 4096);
                v = v >> 4;
            end
        end
    endtask

    task automatic send(input bit fl, input int d, input int s);
        @(negedge clk);
        in_valid = 1'b1;
        in_flush = fl;
        in_dist  = 2'(d);
        in_sym   = 8'(s);
        while (!in_ready) @(negedge clk);
        if (fl) begin
            for (int k = 0; k < 4; k++) begin
                exp_q.push_back(mx[7:0]);
                mx = mx >> 8;
            end
            mx = 64'd1 << 23;
        end else begin
            m_sym(d, s);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_flush = 1'b0;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        while (!(in_ready && !out_valid)) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic compare(input string tag);
        check(got_q.size() == exp_q.size(), {tag, " length"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            check(got_q[i] == exp_q[i], tag, got_q[i], exp_q[i]);
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic load_dist(input int d, input int off, input int n);
        off_m[d] = off;
        len_m[d] = n;
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            tbl_we   = 1'b1;
            tbl_addr = 6'(off + i);
            tbl_cdf  = 17'(cdf_m[off + i]);
            tbl_rcp  = (i < n) ? 33'((64'd1 << 32) / 64'(cdf_m[off+i+1] - cdf_m[off+i])) : '0;
        end
        @(negedge clk);
        tbl_we  = 1'b0;
        dsc_we  = 1'b1;
        dsc_idx = 2'(d);
        dsc_off = 6'(off);
        dsc_len = 6'(n);
        @(negedge clk);
        dsc_we = 1'b0;
    endtask

    // watchdog: a hung run still reaches the summary line
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'h1c3a));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);

        // distribution 0: extreme frequencies, including f=1
        cdf_m[0] = 0; cdf_m[1] = 1; cdf_m[2] = 30000;
        cdf_m[3] = 60000; cdf_m[4] = 65535; cdf_m[5] = 65536;
        load_dist(0, 0, 5);
        // distribution 1: random monotone table
        cdf_m[6] = 0; cdf_m[15] = 65536;
        for (int i = 1; i < 9; i++) cdf_m[6+i] = i * 7000 + int'($urandom % 3000);
        load_dist(1, 6, 9);
        // distribution 2: uniform
        for (int i = 0; i <= 16; i++) cdf_m[16+i] = i * 4096;
        load_dist(2, 16, 16);

        // R1 and R7: flush straight after reset gives 00 00 80 00
        send(1, 0, 0);
        drain();
        check(got_q.size() == 4 && got_q[2] == 8'h80 && got_q[3] == 8'h00, "R1 flush bytes",
              got_q.size(), 4);
        compare("R7 flush");

        // R5: frequency 1 repeatedly, then a large frequency (R4 renorm bounds)
        for (int i = 0; i < 6; i++) send(0, 0, 0);
        for (int i = 0; i < 4; i++) send(0, 0, 1);
        send(1, 0, 0);
        drain();
        compare("R4/R5 extreme freq");

        // R6: escapes at exactly n-1 and far beyond it
        send(0, 0, 4);
        send(0, 0, 255);
        send(0, 1, 8);
        send(0, 1, 200);
        send(0, 2, 15);
        send(1, 0, 0);
        drain();
        compare("R6 escape");

        // R2/R3/R8: random symbols across packed distributions
        for (int i = 0; i < 300; i++) send(0, int'($urandom % 3), int'($urandom % 24));
        send(1, 0, 0);
        drain();
        compare("R2/R3/R8 random");

        // R9: stall the consumer until the FIFO fills
        @(posedge clk); #1 out_ready = 1'b0;
        sender_done = 1'b0;
        fork
            begin
                for (int i = 0; i < 40; i++) send(0, 2, int'($urandom % 15));
                send(1, 0, 0);
                sender_done = 1'b1;
            end
        join_none
        repeat (400) @(negedge clk);
        check(in_ready == 1'b0, "R9 in_ready under full", in_ready, 0);
        check(out_valid == 1'b1, "R9 out_valid under full", out_valid, 1);
        check(got_q.size() == 0, "R9 nothing taken", got_q.size(), 0);
        @(posedge clk); #1 out_ready = 1'b1;
        while (!sender_done) @(negedge clk);
        drain();
        compare("R9 backpressure");

        finish_run();
    end
endmodule